// File: doc/BRIEF.md
# Three-Channel Doorbell Mailbox

This block lets a local processor signal a remote one through three fixed channels. Each channel keeps a 32-bit word of pending doorbell flags. Software sets flags through one register, clears them through another and reads the whole word through a third. Any raised flag in a channel drives that channel's interrupt line toward the receiver.

The receiver gives no separate acknowledgement. The sender polls the channel word until the receiver has cleared the flags it consumed. Channel 0 carries low-priority non-secure traffic and channel 1 high-priority non-secure traffic. Channel 2 is reserved for secure software. A non-secure access to channel 2 returns nothing, changes nothing and completes with an error response.

The register interface is an APB slave in a 4 KB window, clocked by the peripheral clock, with no wait states.

Top module: `apb_doorbell_mbox`

## Requirements
- R1: While reset is low and after reset is released, every channel word is zero and all three interrupt outputs are low.
- R2: Channel c occupies the bytes from 0x20*c. Its word reads at offset +0x0, flags are set at +0x4 and cleared at +0x8. A read of the set or clear offset returns zero without error.
- R3: A write to a channel's set offset makes every bit written as 1 equal to 1 and leaves every other bit of that word unchanged.
- R4: A write to a channel's clear offset makes every bit written as 1 equal to 0 and leaves every other bit of that word unchanged.
- R5: irq[c] equals the OR of the 32 bits of channel c's word as it stood one clock earlier. irq[0] is the low-priority non-secure line, irq[1] the high-priority non-secure line and irq[2] the secure line.
- R6: A write to one channel leaves the words of the other two channels unchanged.
- R7: An access with pprot[1]=1 anywhere in 0x40..0x5F reads zero, leaves channel 2 unchanged and asserts pslverr.
- R8: An access with pprot[1]=0 to channel 2 behaves like an access to any other channel, with no error.
- R9: An access to an unmapped offset reads zero, changes no channel and asserts pslverr. Unmapped offsets are those at or above 0x60 and those within a channel block other than +0x0, +0x4 and +0x8.
- R10: pready is always 1. A write to a word's read offset is ignored and does not raise an error.
- R11: A write takes effect at the clock edge that ends its access phase, so the word read in the following transfer reflects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB peripheral clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | AW | Byte address within the window |
| pwdata | input | W | Write data |
| pprot | input | 3 | Protection attributes; bit 1 set = non-secure |
| prdata | output | W | Read data, valid in the access phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Error response for denied or unmapped accesses |
| irq | output | 3 | Per-channel interrupt, registered |

## Verification
Several properties are checked on every cycle:
- each interrupt follows the OR of its channel word one clock later;
- pready never drops;
- non-secure accesses to channel 2 return zero with an error and leave the word unchanged;
- out-of-window accesses error;
- set and clear writes act on the written bits in the following cycle.

Other behaviour only shows up across whole transfer sequences, so the bench's scenarios and a free-running reference model cover it. This includes:
- isolation between channels;
- zero reads from the write-only offsets;
- writes to the read offset being ignored;
- the unmapped holes inside each channel block;
- set and clear traffic interleaved over many random transfers.

// File: rtl/apb_doorbell_mbox.sv
module apb_doorbell_mbox #(
  parameter int W  = 32,
  parameter int AW = 12
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [W-1:0]  pwdata,
  input  logic [2:0]    pprot,
  output logic [W-1:0]  prdata,
  output logic          pready,
  output logic          pslverr,
  output logic [2:0]    irq
);
  localparam int NCH = 3;

  logic [NCH-1:0][W-1:0] stat;
  logic [1:0] ch;
  logic       acc, in_win, is_rd, is_set, is_clr, denied, ok;

  assign acc    = psel & penable;
  assign ch     = paddr[6:5];
  assign in_win = (paddr[AW-1:7] == '0) && (ch != 2'd3);
  assign is_rd  = in_win && (paddr[4:0] == 5'h00);
  assign is_set = in_win && (paddr[4:0] == 5'h04);
  assign is_clr = in_win && (paddr[4:0] == 5'h08);
  assign denied = (ch == 2'd2) && pprot[1];
  assign ok     = (is_rd | is_set | is_clr) & ~denied;

  assign pready  = 1'b1;
  assign pslverr = acc & ~ok;
  assign prdata  = (acc && !pwrite && ok && is_rd) ? stat[ch] : '0;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    logic [W-1:0] s_msk, c_msk;
    assign hit   = acc & pwrite & ok & (ch == c[1:0]);
    assign s_msk = (hit & is_set) ? pwdata : '0;
    assign c_msk = (hit & is_clr) ? pwdata : '0;

    always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn) begin
        stat[c] <= '0;
        irq[c]  <= 1'b0;
      end else begin
        stat[c] <= (stat[c] | s_msk) & ~c_msk;
        irq[c]  <= |stat[c];
      end
    end
  end
endmodule

// File: rtl/apb_doorbell_mbox_chk.sv
module apb_doorbell_mbox_chk #(
  parameter int W  = 32,
  parameter int AW = 12
) (
  input logic                pclk,
  input logic                presetn,
  input logic                psel,
  input logic                penable,
  input logic                pwrite,
  input logic [AW-1:0]       paddr,
  input logic [W-1:0]        pwdata,
  input logic [2:0]          pprot,
  input logic [W-1:0]        prdata,
  input logic                pready,
  input logic                pslverr,
  input logic [2:0]          irq,
  input logic [2:0][W-1:0]   stat
);
  assert_reset_R1: assert property (@(posedge pclk)
    !presetn |=> (stat == '0) && (irq == 3'b000));

  assert_pready_R10: assert property (@(posedge pclk) disable iff (!presetn)
    pready == 1'b1);

  assert_ns_block_R7: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && pprot[1] && paddr[AW-1:5] == 2) |-> (pslverr && prdata == '0));

  assert_ns_nowrite_R7: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && pwrite && pprot[1] && paddr[AW-1:5] == 2) |=> $stable(stat[2]));

  assert_unmapped_R9: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && paddr[AW-1:7] != 0) |-> (pslverr && prdata == '0));

  for (genvar c = 0; c < 3; c++) begin : g_c
    assert_irq_follow_R5: assert property (@(posedge pclk) disable iff (!presetn)
      1'b1 |=> (irq[c] == (|$past(stat[c]))));

    assert_set_R3: assert property (@(posedge pclk) disable iff (!presetn)
      (psel && penable && pwrite && !pslverr && paddr[AW-1:5] == c && paddr[4:0] == 5'h04)
      |=> ((stat[c] & $past(pwdata)) == $past(pwdata)));

    assert_clr_R4: assert property (@(posedge pclk) disable iff (!presetn)
      (psel && penable && pwrite && !pslverr && paddr[AW-1:5] == c && paddr[4:0] == 5'h08)
      |=> ((stat[c] & $past(pwdata)) == '0));
  end
endmodule

bind apb_doorbell_mbox apb_doorbell_mbox_chk #(.W(W), .AW(AW)) u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
  .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pprot(pprot),
  .prdata(prdata), .pready(pready), .pslverr(pslverr), .irq(irq),
  .stat(stat)
);

// File: tb/sim_apb_doorbell_mbox.sv
`timescale 1ns/1ps
module sim_apb_doorbell_mbox;
  logic        pclk = 0, presetn = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = 0;
  logic [31:0] pwdata = 0;
  logic [2:0]  pprot = 0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [2:0]  irq;

  apb_doorbell_mbox u0 (.*);

  always #4 pclk = ~pclk;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  logic [31:0] m_stat [3];
  logic [2:0]  m_irq;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void decode(input int a, input bit ns, output int kind, output int ch);
    ch = a / 32;
    kind = 0;
    if (a < 96 && !(ch == 2 && ns))
      case (a % 32)
        0: kind = 1;
        4: kind = 2;
        8: kind = 3;
        default: kind = 0;
      endcase
  endfunction

  int mk, mc;
  always @(posedge pclk) begin
    if (!presetn) begin
      for (int i = 0; i < 3; i++) m_stat[i] <= 0;
      m_irq <= 0;
    end else begin
      m_irq <= {|m_stat[2], |m_stat[1], |m_stat[0]};
      if (psel && penable && pwrite) begin
        decode(int'(paddr), pprot[1], mk, mc);
        if (mk == 2) m_stat[mc] <= m_stat[mc] | pwdata;
        if (mk == 3) m_stat[mc] <= m_stat[mc] & ~pwdata;
      end
    end
  end

  always @(negedge pclk) begin
    cycles++;
    if (!done) begin
      if (!presetn) chk(irq == 3'b000, "R1 irq in reset", {29'b0, irq}, 0);
      else begin
        chk(irq == m_irq, "R5 irq", {29'b0, irq}, {29'b0, m_irq});
        chk(pready == 1'b1, "R10 pready", {31'b0, pready}, 1);
      end
    end
    if (cycles > 50000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<50000", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic xfer(input int a, input logic [31:0] d, input bit wr, input bit ns, input string req);
    int k, c;
    logic [31:0] expd;
    @(negedge pclk);
    psel = 1; penable = 0; paddr = a[11:0]; pwdata = d; pwrite = wr;
    pprot = ns ? 3'b010 : 3'b000;
    @(negedge pclk);
    penable = 1;
    #1;
    decode(a, ns, k, c);
    expd = (!wr && k == 1) ? m_stat[c] : 32'h0;
    chk(pslverr == (k == 0), {req, " pslverr"}, {31'b0, pslverr}, {31'b0, k == 0});
    if (!wr) chk(prdata == expd, {req, " prdata"}, prdata, expd);
    @(negedge pclk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1;
    for (int c = 0; c < 3; c++) xfer(c * 32, 0, 0, 0, "R1 reset word");
    xfer(32'h00, 0, 0, 0, "R1 status zero");
    xfer(32'h04, 32'h0000_0001, 1, 0, "R3 set bit0 ch0");
    xfer(32'h00, 0, 0, 0, "R11 readback ch0");
    xfer(32'h24, 32'h8000_0000, 1, 1, "R3 set msb ch1");
    xfer(32'h04, 32'h0000_00F0, 1, 0, "R3 set more ch0");
    xfer(32'h00, 0, 0, 0, "R3 ch0 word");
    xfer(32'h20, 0, 0, 0, "R6 ch1 word");
    xfer(32'h40, 0, 0, 0, "R6 ch2 untouched");
    xfer(32'h08, 32'h0000_0011, 1, 0, "R4 clear ch0");
    xfer(32'h00, 0, 0, 0, "R4 ch0 word");
    xfer(32'h04, 0, 0, 0, "R2 set offset reads zero");
    xfer(32'h28, 0, 0, 1, "R2 clear offset reads zero");
    xfer(32'h00, 32'hFFFF_FFFF, 1, 0, "R10 write to read offset");
    xfer(32'h00, 0, 0, 0, "R10 word unchanged");
    xfer(32'h44, 32'h0000_0F00, 1, 1, "R7 ns set ch2");
    xfer(32'h40, 0, 0, 0, "R7 ch2 still zero");
    xfer(32'h44, 32'h0000_0F00, 1, 0, "R8 secure set ch2");
    xfer(32'h40, 0, 0, 1, "R7 ns read ch2");
    xfer(32'h40, 0, 0, 0, "R8 secure read ch2");
    xfer(32'h48, 32'h0000_0F00, 1, 1, "R7 ns clear ch2");
    xfer(32'h40, 0, 0, 0, "R7 ch2 kept");
    xfer(32'h0C, 32'hFFFF_FFFF, 1, 0, "R9 hole write");
    xfer(32'h60, 0, 0, 0, "R9 above map");
    xfer(32'h100, 32'hFFFF_FFFF, 1, 0, "R9 far write");
    xfer(32'h02, 0, 0, 0, "R9 misaligned");
    xfer(32'h00, 0, 0, 0, "R9 ch0 unchanged");
    xfer(32'h08, 32'hFFFF_FFFF, 1, 0, "R4 clear all ch0");
    xfer(32'h28, 32'hFFFF_FFFF, 1, 0, "R4 clear all ch1");
    xfer(32'h48, 32'hFFFF_FFFF, 1, 0, "R4 clear all ch2");
    repeat (3) @(negedge pclk);
    for (int i = 0; i < 400; i++) begin
      int a;
      a = ($urandom_range(0, 9) == 0) ? 32'h100 : ($urandom_range(0, 31) * 4);
      xfer(a, $urandom, $urandom_range(0, 1), $urandom_range(0, 1), "R6 random");
    end
    repeat (3) @(negedge pclk);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule